// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Beat Order

This block is a small synchronous memory with a burst-address front end. On every rising clock edge it samples two chip selects, two address strobes and an advance input. An accepted strobe captures a full external word address and begins a four-beat burst. Each later cycle with the advance input asserted performs one more access. Only the two least-significant address bits move during a burst. They step in either a counting order or an XOR order, chosen by a mode pin.

The stored word is 18 bits wide and holds two 9-bit lanes. Each lane is a data byte with its parity bit as the lane's top bit, and each lane has its own write enable. One strobe is meant for a processor and only ever starts reads. The other is meant for a memory controller and starts a read or a write, as set by a write pin. If the chip is not selected, that strobe deselects the block instead. A snooze input freezes the block in a low-power state. The output-enable pin gates the read-data drivers combinationally.

Top module: `sburst_sram`

## Requirements
- R1: With `order_sel` low (counting order), the beat-k address low bits equal (start low bits + k) mod 4.
- R2: With `order_sel` high (XOR order), the beat-k address low bits equal start low bits XOR k. The order is taken when the burst starts.
- R3: A cycle with a burst active, no accepted strobe and `adv_n` high is a wait cycle. No access is made, the beat position does not move, and `rd_data` holds its value.
- R4: During a burst the address bits above bit 1 keep their captured value. An advance after the fourth beat wraps back to the start address.
- R5: The processor strobe `pstb_n` takes effect only while `sel_n` is low, and it always starts a read whatever `wr_n` shows. While `sel_n` is high it is ignored.
- R6: The controller strobe `cstb_n` starts a write when `wr_n` is low and a read otherwise. If either chip select is inactive, it deselects the block instead: the outputs turn off and later advances do nothing.
- R7: If both strobes are valid in one cycle, the processor strobe wins, and the access is a read.
- R8: While `snooze` is high, strobes and advances are ignored and nothing is written. The outputs are off, and the stored contents and the read state come back unchanged when `snooze` drops.
- R9: Lane 0 is bits 8:0 (parity at bit 8) and is written only when `lane_we_n[0]` is low. Lane 1 is bits 17:9 (parity at bit 17) and is written only when `lane_we_n[1]` is low.
- R10: Read data for an accepted address is shown after the edge that accepts it. `rd_en` follows `oe_n` at once, with no clock edge, and `rd_data` is zero whenever `rd_en` is low.
- R11: After reset no burst is active and `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| sel_p | input | 1 | Chip select, active high |
| pstb_n | input | 1 | Processor address strobe, active low, read only |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high means wait |
| wr_n | input | 1 | Write select for the controller strobe, active low |
| lane_we_n | input | 2 | Per-lane write enables, active low |
| order_sel | input | 1 | Beat order: 0 counting, 1 XOR |
| snooze | input | 1 | Low-power standby, active high |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | External word address |
| wr_data | input | 18 | Write data, two 9-bit lanes |
| rd_data | output | 18 | Read data, zero when not driven |
| rd_en | output | 1 | Read-data drivers on (low means high impedance) |

## Verification
The bench builds the block with `ADDR_W` set to 4, which gives a 16-word array. At that size every word can be pre-written and followed in a bench-side model. Bursts then start at several low-bit offsets within four different upper-address groups, so counting wrap, XOR patterns and the wrap after the fourth beat can all be seen in a handful of cycles. The small depth also keeps the priority, snooze and deselect cases cheap to check by reading back the exact words they could have changed.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  localparam int BEATS    = 4;
  localparam int LANE_W   = 9;
  localparam int LANES    = 2;
  localparam int WORD_W   = LANE_W * LANES;

  typedef enum logic {
    ORD_COUNT = 1'b0,
    ORD_XOR   = 1'b1
  } beat_order_e;

  // Low address bits of a given beat, relative to the burst start.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input beat_order_e ord);
    logic [1:0] r;
    if (ord == ORD_COUNT) r = start + beat;
    else                  r = start ^ beat;
    return r;
  endfunction

  function automatic logic [1:0] beat_next(input logic [1:0] beat);
    return beat + 2'd1;
  endfunction

endpackage

// File: rtl/sburst_seq.sv
module sburst_seq
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic              adv_n,
  input  logic              wr_n,
  input  logic              order_sel,
  input  logic              snooze,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_vld,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              desel_evt,
  output logic              burst_active
);

  logic              chip_on;
  logic              p_hit, c_hit, strobe_hit;
  logic              start_evt, adv_evt, hold_evt;
  logic              active_q, wr_q;
  beat_order_e       ord_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q, beat_nx;
  logic [ADDR_W-1:0] last_addr_q;

  assign chip_on    = !sel_n && sel_p;
  assign p_hit      = !snooze && !pstb_n && !sel_n;
  assign c_hit      = !snooze && !cstb_n && !p_hit;
  assign strobe_hit = p_hit || c_hit;
  assign start_evt  = strobe_hit && chip_on;
  assign desel_evt  = strobe_hit && !chip_on;
  assign adv_evt    = !snooze && !strobe_hit && active_q && !adv_n;
  assign hold_evt   = !snooze && !strobe_hit && active_q && adv_n;
  assign beat_nx    = beat_next(beat_q);

  always_comb begin
    if (start_evt) begin
      acc_addr = addr;
      acc_wr   = c_hit && !wr_n;
    end else begin
      acc_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_nx, ord_q)};
      acc_wr   = wr_q;
    end
  end

  assign acc_vld      = start_evt || adv_evt;
  assign burst_active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      wr_q        <= 1'b0;
      ord_q       <= ORD_COUNT;
      base_q      <= '0;
      beat_q      <= '0;
      last_addr_q <= '0;
    end else begin
      if (start_evt) begin
        active_q <= 1'b1;
        wr_q     <= c_hit && !wr_n;
        ord_q    <= beat_order_e'(order_sel);
        base_q   <= addr;
        beat_q   <= 2'd0;
      end else if (desel_evt) begin
        active_q <= 1'b0;
        wr_q     <= 1'b0;
      end else if (adv_evt) begin
        beat_q   <= beat_nx;
      end
      if (acc_vld) last_addr_q <= acc_addr;
    end
  end

  // R3: a wait cycle leaves the burst position untouched
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> ($stable(beat_q) && $stable(base_q)));

  // R1: counting order steps the low bits by one from the previous beat
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && ord_q == ORD_COUNT) |-> (acc_addr[1:0] == last_addr_q[1:0] + 2'd1));

  // R2: XOR order differs from the previous beat by beat^(beat+1)
  a_r2_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && ord_q == ORD_XOR) |->
      ((acc_addr[1:0] ^ last_addr_q[1:0]) == (beat_q ^ beat_nx)));

  // R4: upper bits stay fixed across advances
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |-> (acc_addr[ADDR_W-1:2] == last_addr_q[ADDR_W-1:2]));

  // R8: no access during snooze
  a_r8_snooze_idle: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !acc_vld);

endmodule

// File: rtl/sburst_mem.sv
module sburst_mem
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic              lane_wr;

    assign lane_wr = acc_vld && acc_wr && !lane_we_n[g];

    always_ff @(posedge clk) begin
      if (lane_wr) bank[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
      if (acc_vld && !acc_wr) rd_q <= bank[acc_addr];
    end

    assign rd_word[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic              adv_n,
  input  logic              wr_n,
  input  logic [1:0]        lane_we_n,
  input  logic              order_sel,
  input  logic              snooze,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [17:0]       wr_data,
  output logic [17:0]       rd_data,
  output logic              rd_en
);

  logic              acc_vld, acc_wr, desel_evt, burst_active;
  logic [ADDR_W-1:0] acc_addr;
  logic [WORD_W-1:0] rd_word;
  logic              rd_live_q;

  sburst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .wr_n(wr_n),
    .order_sel(order_sel), .snooze(snooze), .addr(addr),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .desel_evt(desel_evt), .burst_active(burst_active)
  );

  sburst_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .lane_we_n(lane_we_n), .wr_data(wr_data), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_live_q <= 1'b0;
    else if (acc_vld)   rd_live_q <= !acc_wr;
    else if (desel_evt) rd_live_q <= 1'b0;
  end

  assign rd_en   = rd_live_q && !oe_n && !snooze;
  assign rd_data = rd_en ? rd_word : '0;

  // R7: both strobes valid on a selected chip never write
  a_r7_proc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && !cstb_n && !sel_n && sel_p && !snooze) |-> (acc_vld && !acc_wr));

  // R10: a read access drives the outputs on the next cycle when enabled
  a_r10_read_next: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_wr) |=> (oe_n || snooze || rd_en));

  // R6: deselect turns the drivers off and ends the burst
  a_r6_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
    desel_evt |=> (!rd_en && !burst_active));

  // R11: nothing active coming out of reset
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!rd_en && !burst_active));

endmodule

// File: tb/sburst_sram_test.sv
module sburst_sram_test;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b0, sel_p = 1'b1;
  logic          pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1, wr_n = 1'b1;
  logic [1:0]    lane_we_n = 2'b00;
  logic          order_sel = 1'b0, snooze = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0]   wr_data = '0;
  logic [17:0]   rd_data;
  logic          rd_en;

  int checks = 0;
  int errors = 0;
  logic [17:0] mdl [DEPTH];

  sburst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .wr_n(wr_n),
    .lane_we_n(lane_we_n), .order_sel(order_sel), .snooze(snooze),
    .oe_n(oe_n), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_en(rd_en)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] lin_addr(input logic [AW-1:0] a, input int k);
    logic [1:0] lo;
    lo = a[1:0] + 2'(k);
    return {a[AW-1:2], lo};
  endfunction

  function automatic logic [AW-1:0] xor_addr(input logic [AW-1:0] a, input int k);
    logic [1:0] lo;
    lo = a[1:0] ^ 2'(k);
    return {a[AW-1:2], lo};
  endfunction

  function automatic logic [17:0] pat(input int a, input int salt);
    return 18'((a * 18'h1357) ^ (salt * 18'h2a5c) ^ 18'h0f0f1);
  endfunction

  task automatic start_c(input logic [AW-1:0] a, input logic wr, input logic [17:0] d);
    addr = a; cstb_n = 1'b0; wr_n = !wr; wr_data = d;
    tick();
    cstb_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic step(input logic [17:0] d);
    adv_n = 1'b0; wr_data = d;
    tick();
    adv_n = 1'b1;
  endtask

  // Read a four-beat burst and compare each beat with the model.
  task automatic read_burst(input string req, input logic [AW-1:0] a, input logic ord);
    order_sel = ord;
    start_c(a, 1'b0, '0);
    chk(req, rd_data, mdl[a]);
    for (int k = 1; k < 4; k++) begin
      step('0);
      chk(req, rd_data, mdl[ord ? xor_addr(a, k) : lin_addr(a, k)]);
    end
  endtask

  task automatic t_reset();
    chk("R11 rd_en", rd_en, 0);
    chk("R11 rd_data", rd_data, 0);
  endtask

  task automatic t_fill();
    for (int b = 0; b < DEPTH; b += 4) begin
      order_sel = 1'b0;
      start_c(AW'(b), 1'b1, pat(b, 1));
      mdl[b] = pat(b, 1);
      chk("R6 write off", rd_en, 0);
      for (int k = 1; k < 4; k++) begin
        step(pat(b + k, 1));
        mdl[b + k] = pat(b + k, 1);
      end
    end
  endtask

  task automatic t_count();
    read_burst("R1 count from 2", AW'(2), 1'b0);
    read_burst("R1 count from 11", AW'(11), 1'b0);
  endtask

  task automatic t_xor();
    read_burst("R2 xor from 5", AW'(5), 1'b1);
    step('0);
    chk("R4 wrap", rd_data, mdl[5]);
    step('0);
    chk("R4 upper fixed", rd_data, mdl[4]);
  endtask

  task automatic t_wait();
    order_sel = 1'b0;
    start_c(AW'(9), 1'b0, '0);
    step('0);
    chk("R3 beat1", rd_data, mdl[10]);
    tick();
    chk("R3 wait hold", rd_data, mdl[10]);
    tick();
    chk("R3 wait hold2", rd_data, mdl[10]);
    step('0);
    chk("R3 no skip", rd_data, mdl[11]);
  endtask

  task automatic t_xor_write();
    logic [AW-1:0] seq [4];
    order_sel = 1'b1;
    for (int k = 0; k < 4; k++) seq[k] = xor_addr(AW'(14), k);
    start_c(AW'(14), 1'b1, pat(14, 2));
    mdl[seq[0]] = pat(14, 2);
    step(pat(15, 2)); mdl[seq[1]] = pat(15, 2);
    wr_data = 18'h3ffff;
    tick();
    step(pat(12, 2)); mdl[seq[2]] = pat(12, 2);
    step(pat(13, 2)); mdl[seq[3]] = pat(13, 2);
    read_burst("R2 xor write", AW'(12), 1'b0);
    read_burst("R3 wait no write", AW'(14), 1'b1);
  endtask

  task automatic t_lanes();
    order_sel = 1'b0;
    lane_we_n = 2'b10;
    start_c(AW'(3), 1'b1, 18'h3ffff);
    mdl[3][8:0] = 9'h1ff;
    lane_we_n = 2'b01;
    start_c(AW'(6), 1'b1, 18'h20000);
    mdl[6][17:9] = 9'h100;
    lane_we_n = 2'b00;
    start_c(AW'(3), 1'b0, '0);
    chk("R9 lane0 parity", rd_data, mdl[3]);
    start_c(AW'(6), 1'b0, '0);
    chk("R9 lane1 parity", rd_data, mdl[6]);
  endtask

  task automatic t_proc();
    addr = AW'(8); pstb_n = 1'b0; wr_n = 1'b0; wr_data = 18'h15555;
    tick();
    pstb_n = 1'b1; wr_n = 1'b1;
    chk("R5 proc read", rd_data, mdl[8]);
    chk("R5 proc rd_en", rd_en, 1);
    sel_n = 1'b1; addr = AW'(0); pstb_n = 1'b0;
    tick();
    pstb_n = 1'b1; sel_n = 1'b0;
    chk("R5 ignored", rd_data, mdl[8]);
    start_c(AW'(8), 1'b0, '0);
    chk("R5 no write", rd_data, mdl[8]);
  endtask

  task automatic t_both();
    addr = AW'(7); pstb_n = 1'b0; cstb_n = 1'b0; wr_n = 1'b0; wr_data = 18'h2aaaa;
    tick();
    pstb_n = 1'b1; cstb_n = 1'b1; wr_n = 1'b1;
    chk("R7 read wins", rd_data, mdl[7]);
    start_c(AW'(1), 1'b0, '0);
    start_c(AW'(7), 1'b0, '0);
    chk("R7 no write", rd_data, mdl[7]);
  endtask

  task automatic t_desel();
    start_c(AW'(2), 1'b0, '0);
    sel_p = 1'b0;
    start_c(AW'(3), 1'b0, '0);
    sel_p = 1'b1;
    chk("R6 desel off", rd_en, 0);
    step('0);
    chk("R6 adv after desel", rd_en, 0);
  endtask

  task automatic t_snooze();
    start_c(AW'(1), 1'b0, '0);
    snooze = 1'b1;
    #1;
    chk("R8 outputs off", rd_en, 0);
    start_c(AW'(1), 1'b1, 18'h00001);
    step('0);
    snooze = 1'b0;
    #1;
    chk("R8 state kept", rd_data, mdl[1]);
    step('0);
    chk("R8 burst kept", rd_data, mdl[2]);
    start_c(AW'(1), 1'b0, '0);
    chk("R8 no write", rd_data, mdl[1]);
  endtask

  task automatic t_oe();
    start_c(AW'(4), 1'b0, '0);
    oe_n = 1'b1;
    #1;
    chk("R10 oe off", rd_en, 0);
    chk("R10 zero data", rd_data, 0);
    oe_n = 1'b0;
    #1;
    chk("R10 oe on", rd_data, mdl[4]);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_count();
    t_xor();
    t_wait();
    t_xor_write();
    t_lanes();
    t_proc();
    t_both();
    t_desel();
    t_snooze();
    t_oe();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule